// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop is locked by watching the two pulse streams that feed its phase detector: the reference and the feedback divider output. Each stream first passes through a two-flop synchronizer. Its rising edges are then detected on a fast sampling clock. Both edge streams are divided by 64, so one comparison is made for every 64 input periods. For each comparison the block counts the sampling-clock cycles between the divided leading edge that arrives first and the matching edge on the other stream. The count is then judged against a window that software supplies as a number of sampling cycles.

A filter turns the individual comparisons into a lock flag. Four hits in a row are needed to assert lock. One miss removes it at once and starts the count of hits again from zero. A comparison in which the second edge never comes within 64 window lengths counts as a miss. A control input can hold the output low at any time without disturbing the filter.

Top module: `pll_lock_detect`

## Requirements
- R1: Each input is divided by 64 before comparison. After reset, rising edges 1, 65, 129, … of each input are its leading edges. Rising edges between them have no effect on the result.
- R2: The error is the number of sampling-clock cycles between the two leading edges, whichever input leads. A comparison is a hit when error < `win_cycles`. An error equal to or greater than `win_cycles` is a miss. Two leading edges in the same cycle give an error of 0.
- R3: `lock_out` rises after the fourth hit in a row and stays high while the hits continue. Fewer than four hits in a row leave it low.
- R4: A single miss drives the internal lock low. The following three hits keep it low, and only the fourth hit brings it back.
- R5: While `ld_enable` is 0, `lock_out` is 0. The filter keeps running, so when `ld_enable` returns to 1, `lock_out` shows the filter's current lock state.
- R6: If the second leading edge has not arrived 64×`win_cycles` sampling cycles after the first, the comparison is a miss and the detector waits for a new first edge.
- R7: During and right after a synchronous active-low reset, `lock_out` is 0. The hit count and the divider phase are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference pulse stream, asynchronous |
| fb_in | input | 1 | Feedback pulse stream, asynchronous |
| ld_enable | input | 1 | 1 = show lock status, 0 = force output low |
| win_cycles | input | WIN_W (8) | Phase window in sampling-clock cycles |
| lock_out | output | 1 | Filtered lock indication |

## Verification
The assertions check several properties on every cycle. A divided edge is never followed by another in the next cycle. Any miss clears lock in the next cycle. Lock can only rise directly after a hit. The hit count never passes four, and a comparison that reaches its timeout limit always returns to idle. Only the bench scenarios can show the window boundary at error = window, the symmetry between reference-leading and feedback-leading cases, and the fact that the divider really skips 63 of every 64 edges. The same holds for the timeout restart and for filter state surviving a period with the output disabled.

// File: rtl/lockdet_pkg.sv
// Package lockdet_pkg
// Types shared by the lock-detector modules.
// Assumes: nothing beyond IEEE 1800-2017.
package lockdet_pkg;

    // State of the phase comparator
    typedef enum logic [1:0] {
        CMP_IDLE     = 2'd0,
        CMP_WAIT_FB  = 2'd1,
        CMP_WAIT_REF = 2'd2
    } cmp_state_t;

    // Source index for the two edge chains
    localparam int SRC_REF = 0;
    localparam int SRC_FB  = 1;

endpackage

// File: rtl/lockdet_sync_edge.sv
// Module lockdet_sync_edge
// Brings an asynchronous pulse into the sampling-clock domain through two
// flops and emits a one-cycle strobe on each rising edge.
// Assumes: input pulses stay high and low for at least one sampling cycle.
module lockdet_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchronizer plus history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Rising edge of the synchronized level
    always_comb rise_pulse = s2_q & ~s3_q;

endmodule

// File: rtl/lockdet_prediv.sv
// Module lockdet_prediv
// Divides an edge-strobe stream by DIV_RATIO. It passes through the first
// strobe after reset and then every DIV_RATIO-th strobe.
// Assumes: strobes are single-cycle and never in adjacent cycles.
module lockdet_prediv #(
    parameter int DIV_RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    output logic div_pulse
);
    localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] phase_q;

    // Count input strobes modulo DIV_RATIO
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (edge_in)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    // Leading edge: the strobe seen when the phase is zero
    always_comb div_pulse = edge_in && (phase_q == '0);

    // R1: divided strobes are never back to back
    a_r1_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

endmodule

// File: rtl/lockdet_phase_cmp.sv
// Module lockdet_phase_cmp
// Measures the cycles between the divided reference and feedback leading
// edges and classifies each comparison as in or out of window. It also
// ends a comparison as a miss after TIMEOUT_MULT window lengths.
// Assumes: win_cycles is held steady while a comparison is open.
module lockdet_phase_cmp
    import lockdet_pkg::*;
#(
    parameter int WIN_W        = 8,
    parameter int TIMEOUT_MULT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             fb_edge,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             res_valid,
    output logic             res_hit
);
    localparam int TMO_W = WIN_W + $clog2(TIMEOUT_MULT) + 1;

    cmp_state_t       state_q;
    logic [TMO_W-1:0] err_q;
    logic [TMO_W-1:0] limit;
    logic [TMO_W-1:0] win_ext;
    logic             other_edge;

    // Window widened to the counter width, and the timeout limit
    always_comb begin
        win_ext = TMO_W'(win_cycles);
        limit   = win_ext * TMO_W'(TIMEOUT_MULT);
    end

    // The edge that closes the open comparison
    always_comb other_edge = (state_q == CMP_WAIT_FB)  ? fb_edge :
                             (state_q == CMP_WAIT_REF) ? ref_edge : 1'b0;

    // Comparison sequencer: open on first edge, close on other edge or timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= CMP_IDLE;
            err_q     <= '0;
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state_q)
                CMP_IDLE: begin
                    if (ref_edge && fb_edge) begin
                        res_valid <= 1'b1;
                        res_hit   <= (win_ext != '0);
                    end else if (ref_edge) begin
                        state_q <= CMP_WAIT_FB;
                        err_q   <= TMO_W'(1);
                    end else if (fb_edge) begin
                        state_q <= CMP_WAIT_REF;
                        err_q   <= TMO_W'(1);
                    end
                end
                default: begin
                    if (other_edge) begin
                        res_valid <= 1'b1;
                        res_hit   <= (err_q < win_ext);
                        state_q   <= CMP_IDLE;
                    end else if (err_q >= limit) begin
                        res_valid <= 1'b1;
                        res_hit   <= 1'b0;
                        state_q   <= CMP_IDLE;
                    end else begin
                        err_q <= err_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // R6: an open comparison that reaches its limit without the other edge closes
    a_r6_timeout_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CMP_IDLE && !other_edge && err_q >= limit)
            |=> (state_q == CMP_IDLE && res_valid && !res_hit));

endmodule

// File: rtl/lockdet_filter.sv
// Module lockdet_filter
// Filters comparison results: lock after LOCK_COUNT consecutive hits,
// loss of lock on the first miss.
// Assumes: res_valid is a single-cycle strobe.
module lockdet_filter #(
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_valid,
    input  logic res_hit,
    output logic locked
);
    localparam int HC_W = $clog2(LOCK_COUNT + 1);
    localparam logic [HC_W-1:0] FULL = HC_W'(LOCK_COUNT);

    logic [HC_W-1:0] hits_q;
    logic [HC_W-1:0] hits_nx;

    // Next saturating hit count
    always_comb hits_nx = (hits_q == FULL) ? FULL : hits_q + 1'b1;

    // Consecutive-hit counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits_q <= '0;
            locked <= 1'b0;
        end else if (res_valid) begin
            if (res_hit) begin
                hits_q <= hits_nx;
                locked <= (hits_nx == FULL);
            end else begin
                hits_q <= '0;
                locked <= 1'b0;
            end
        end
    end

    // R4: a miss clears lock on the next cycle
    a_r4_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |=> !locked);

    // R3: lock only rises right after a hit
    a_r3_rise_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(res_valid && res_hit));

    // R3: the hit count never passes its saturation value
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hits_q <= FULL);

endmodule

// File: rtl/pll_lock_detect.sv
// Module pll_lock_detect
// Digital filtered lock detector. It synchronizes and edge-detects the
// reference and feedback pulses, divides each by DIV_RATIO, measures leading-edge
// skew against a window and filters the result into a lock output.
// Assumes: clk is much faster than the pulse inputs.
module pll_lock_detect
    import lockdet_pkg::*;
#(
    parameter int WIN_W        = 8,
    parameter int DIV_RATIO    = 64,
    parameter int LOCK_COUNT   = 4,
    parameter int TIMEOUT_MULT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             ld_enable,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             lock_out
);
    localparam int N_SRC = 2;

    logic [N_SRC-1:0] raw_in;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] lead;
    logic             res_valid;
    logic             res_hit;
    logic             locked;

    // Gather the two pulse inputs
    always_comb begin
        raw_in[SRC_REF] = ref_in;
        raw_in[SRC_FB]  = fb_in;
    end

    // Identical synchronize-and-divide chain per input
    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        lockdet_sync_edge u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .async_in   (raw_in[g]),
            .rise_pulse (rise[g])
        );
        lockdet_prediv #(.DIV_RATIO(DIV_RATIO)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_in   (rise[g]),
            .div_pulse (lead[g])
        );
    end

    lockdet_phase_cmp #(.WIN_W(WIN_W), .TIMEOUT_MULT(TIMEOUT_MULT)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge   (lead[SRC_REF]),
        .fb_edge    (lead[SRC_FB]),
        .win_cycles (win_cycles),
        .res_valid  (res_valid),
        .res_hit    (res_hit)
    );

    lockdet_filter #(.LOCK_COUNT(LOCK_COUNT)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .locked    (locked)
    );

    // Output gate: enable low forces the indication to ground
    always_comb lock_out = locked & ld_enable;

endmodule

// File: tb/test_pll_lock_detect.sv
// Bench for pll_lock_detect: sweeps leading-edge skew across the window in
// both directions and checks lock against an arithmetic model.
module test_pll_lock_detect;
    localparam int WIN_W = 8;
    localparam int P     = 4;   // pulse period in cycles
    localparam int BASE  = 20;  // first reference edge offset

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic             ld_enable = 1'b1;
    logic [WIN_W-1:0] win_cycles = 8'd8;
    logic             lock_out;

    int n_checks = 0;
    int n_errors = 0;
    int exp_hits = 0;

    always #10 clk = ~clk;  // 50 MHz

    pll_lock_detect i_pll_lock_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .ld_enable  (ld_enable),
        .win_cycles (win_cycles),
        .lock_out   (lock_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: lock_out=%0b expected %0b", req, got, exp);
        end
    endtask

    function automatic bit is_ref(input int c);
        int k = c - BASE;
        return (k >= 0) && (k % P == 0) && (k / P < 64);
    endfunction

    function automatic bit is_fb(input int c, input int d0, input int dr);
        int k = c - BASE - dr;
        if (c == BASE + d0) return 1'b1;
        return (k >= P) && (k % P == 0) && (k / P < 64);
    endfunction

    // One comparison: 64 reference and 64 feedback pulses
    task automatic run_cmp(input int d0, input int dr, input bit with_fb);
        int span = BASE + 64 * P + 40;
        for (int c = 0; c < span; c++) begin
            @(negedge clk);
            ref_in = is_ref(c);
            fb_in  = with_fb && is_fb(c, d0, dr);
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // Model update for one comparison result
    task automatic model(input bit hit);
        if (hit) exp_hits = (exp_hits >= 4) ? 4 : exp_hits + 1;
        else     exp_hits = 0;
    endtask

    function automatic logic exp_lock();
        return (exp_hits >= 4) && ld_enable;
    endfunction

    task automatic sweep(input int w, input int dmin, input int dmax);
        win_cycles = 8'(w);
        for (int d = dmin; d <= dmax; d++) begin
            run_cmp(w + 2, w + 2, 1'b1);
            model(1'b0);
            check(lock_out, exp_lock(), "R4 clear before sweep point");
            for (int r = 0; r < 4; r++) begin
                int ad = (d < 0) ? -d : d;
                run_cmp(d, d, 1'b1);
                model(ad < w);
                if (ad == w || ad == w - 1)
                    check(lock_out, exp_lock(), "R2 window boundary");
                else
                    check(lock_out, exp_lock(), "R3 consecutive hits");
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(lock_out, 1'b0, "R7 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(lock_out, 1'b0, "R7 after reset");

        // R2 R3: skew sweeps in both directions, two window sizes
        sweep(8, -10, 10);
        sweep(3, -3, 3);
        win_cycles = 8'd8;

        // R4: one miss drops lock; count restarts
        for (int r = 0; r < 4; r++) begin run_cmp(2, 2, 1'b1); model(1'b1); end
        check(lock_out, exp_lock(), "R4 locked before miss");
        run_cmp(-9, -9, 1'b1); model(1'b0);
        check(lock_out, exp_lock(), "R4 miss drops lock");
        for (int r = 0; r < 4; r++) begin
            run_cmp(1, 1, 1'b1); model(1'b1);
            check(lock_out, exp_lock(), "R4 restart count");
        end

        // R1: only leading edges count; later edges skewed far out of window
        run_cmp(12, 12, 1'b1); model(1'b0);
        for (int r = 0; r < 4; r++) begin
            run_cmp(0, 11, 1'b1); model(1'b1);
            check(lock_out, exp_lock(), "R1 non-leading edges ignored");
        end

        // R5: enable gating keeps filter state
        ld_enable = 1'b0;
        repeat (3) @(negedge clk);
        check(lock_out, exp_lock(), "R5 disabled output low");
        run_cmp(3, 3, 1'b1); model(1'b1);
        check(lock_out, exp_lock(), "R5 low while disabled");
        ld_enable = 1'b1;
        repeat (3) @(negedge clk);
        check(lock_out, exp_lock(), "R5 state kept on re-enable");

        // R6: missing feedback times out as a miss, then count restarts
        run_cmp(0, 0, 1'b0);
        repeat (600) @(negedge clk);
        model(1'b0);
        check(lock_out, exp_lock(), "R6 timeout clears lock");
        for (int r = 0; r < 4; r++) begin
            run_cmp(-2, -2, 1'b1); model(1'b1);
            check(lock_out, exp_lock(), "R6 recovery after timeout");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule